// File: doc/BRIEF.md
# Fragment Depth and Alpha Test Stage

This block is the per-pixel test stage of a raster back end. Each fragment arrives with its own depth, the depth already held in the depth buffer for that pixel, and its alpha value. The block runs two comparisons on it. The depth test compares the fragment depth with the stored depth. The alpha test compares the fragment alpha with a programmable threshold. It then reports one cycle later whether the fragment survives, whether its depth may be written back, and which depth value to write.

Both tests take a 3-bit compare code from one shared encoding. The code is a mask over the outcomes less, equal and greater, so codes 0 and 7 mean never and always.

A second, purely combinational path serves pixel readback. It returns a peeked alpha byte unchanged, or it forces the byte to all zeros or all ones, depending on a 2-bit mode.

Top module: `frag_test_stage`

## Requirements
- R1: The depth compare code is z_cfg_i[3:1] and tests frag_z_i against stored_z_i, both unsigned: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always.
- R2: When z_cfg_i[0] (depth compare enable) is 0, every fragment passes the depth test whatever the code and values.
- R3: The alpha test compares frag_alpha_i against the threshold alpha_cfg_i[7:0], using the code in alpha_cfg_i[10:8] with the same encoding as R1. Bits alpha_cfg_i[15:11] have no effect.
- R4: pass_o is 1 only when the fragment passes both the depth test and the alpha test.
- R5: z_we_o is 1 only when pass_o is 1 and z_cfg_i[4] (depth update enable) was 1 for that fragment.
- R6: For every accepted fragment, z_wdata_o carries that fragment's frag_z_i.
- R7: The latency is fixed at one cycle: valid_o follows valid_i one clock later. pass_o and z_we_o are 0 whenever valid_o is 0. z_wdata_o holds its value across idle cycles.
- R8: rb_alpha_o is combinational. rb_mode_i 0 gives 8'h00, 1 gives 8'hFF, and 2 or 3 gives rb_alpha_i unchanged.
- R9: While rst_ni is low, valid_o, pass_o and z_we_o are 0 and z_wdata_o is 0.
- R10: Bits z_cfg_i[15:5] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Fragment present this cycle |
| frag_z_i | input | 24 | Fragment depth |
| stored_z_i | input | 24 | Depth currently in the buffer |
| frag_alpha_i | input | 8 | Fragment alpha |
| z_cfg_i | input | 16 | Depth config: [0] enable, [3:1] code, [4] update enable |
| alpha_cfg_i | input | 16 | Alpha config: [7:0] threshold, [10:8] code |
| rb_mode_i | input | 2 | Readback alpha mode |
| rb_alpha_i | input | 8 | Stored alpha of the peeked pixel |
| valid_o | output | 1 | Result present |
| pass_o | output | 1 | Fragment survives both tests |
| z_we_o | output | 1 | Write depth back |
| z_wdata_o | output | 24 | Depth to write |
| rb_alpha_o | output | 8 | Readback alpha after override |

## Verification
The assertions check several rules on every cycle. The one-cycle valid latency holds. A depth write never occurs without a valid, passing result. A cleared update enable always blocks the write. The write data is the previous cycle's fragment depth. Each readback mode maps its input correctly. The exact outcome of each compare code, the combination of the two tests and the masking of reserved configuration bits can only be shown by the bench's table of fragments with known expected results. The same holds for the reset values.

// File: rtl/frag_test_pkg.sv
package frag_test_pkg;

  typedef enum logic [2:0] {
    CMP_NEVER  = 3'd0,
    CMP_LT     = 3'd1,
    CMP_EQ     = 3'd2,
    CMP_LE     = 3'd3,
    CMP_GT     = 3'd4,
    CMP_NE     = 3'd5,
    CMP_GE     = 3'd6,
    CMP_ALWAYS = 3'd7
  } cmp_fn_e;

  typedef enum logic [1:0] {
    RB_ZERO = 2'd0,
    RB_ONES = 2'd1,
    RB_PASS = 2'd2,
    RB_ALT  = 2'd3
  } rb_mode_e;

  // depth config field positions
  localparam int unsigned ZC_EN_BIT  = 0;
  localparam int unsigned ZC_FN_LSB  = 1;
  localparam int unsigned ZC_UPD_BIT = 4;
  localparam int unsigned ZC_USED    = 5;

  localparam int unsigned FN_W = 3;

endpackage

// File: rtl/frag_cmp.sv
module frag_cmp #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  output logic         hit_o
);
  logic lt, eq, gt;

  assign lt = a_i < b_i;
  assign eq = a_i == b_i;
  assign gt = a_i > b_i;

  // code is a mask over {gt, eq, lt}
  assign hit_o = (fn_i[0] & lt) | (fn_i[1] & eq) | (fn_i[2] & gt);
endmodule

// File: rtl/alpha_readback.sv
module alpha_readback
  import frag_test_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] alpha_i,
  output logic [AW-1:0] alpha_o
);
  always_comb begin
    unique case (rb_mode_e'(mode_i))
      RB_ZERO: alpha_o = '0;
      RB_ONES: alpha_o = '1;
      default: alpha_o = alpha_i;
    endcase
  end
endmodule

// File: rtl/frag_test_stage.sv
module frag_test_stage
  import frag_test_pkg::*;
#(
  parameter int unsigned ZW = 24,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [ZW-1:0] frag_z_i,
  input  logic [ZW-1:0] stored_z_i,
  input  logic [AW-1:0] frag_alpha_i,
  input  logic [CW-1:0] z_cfg_i,
  input  logic [CW-1:0] alpha_cfg_i,
  input  logic [1:0]    rb_mode_i,
  input  logic [AW-1:0] rb_alpha_i,
  output logic          valid_o,
  output logic          pass_o,
  output logic          z_we_o,
  output logic [ZW-1:0] z_wdata_o,
  output logic [AW-1:0] rb_alpha_o
);
  localparam int unsigned AC_FN_LSB = AW;
  localparam int unsigned AC_USED   = AW + FN_W;

  logic            z_en, z_upd;
  logic [FN_W-1:0] z_fn, a_fn;
  logic [AW-1:0]   a_thr;
  logic            z_hit, a_hit, z_ok, accept;

  // reserved config bits, not used by the datapath
  logic unused_cfg;
  assign unused_cfg = ^{z_cfg_i[CW-1:ZC_USED], alpha_cfg_i[CW-1:AC_USED]};

  assign z_en  = z_cfg_i[ZC_EN_BIT];
  assign z_upd = z_cfg_i[ZC_UPD_BIT];
  assign z_fn  = z_cfg_i[ZC_FN_LSB +: FN_W];
  assign a_thr = alpha_cfg_i[AW-1:0];
  assign a_fn  = alpha_cfg_i[AC_FN_LSB +: FN_W];

  frag_cmp #(.W(ZW)) u_z_cmp (
    .a_i  (frag_z_i),
    .b_i  (stored_z_i),
    .fn_i (z_fn),
    .hit_o(z_hit)
  );

  frag_cmp #(.W(AW)) u_a_cmp (
    .a_i  (frag_alpha_i),
    .b_i  (a_thr),
    .fn_i (a_fn),
    .hit_o(a_hit)
  );

  assign z_ok   = z_hit | ~z_en;
  assign accept = z_ok & a_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      pass_o    <= 1'b0;
      z_we_o    <= 1'b0;
      z_wdata_o <= '0;
    end else begin
      valid_o <= valid_i;
      pass_o  <= valid_i & accept;
      z_we_o  <= valid_i & accept & z_upd;
      if (valid_i) z_wdata_o <= frag_z_i;
    end
  end

  alpha_readback #(.AW(AW)) u_rb (
    .mode_i (rb_mode_i),
    .alpha_i(rb_alpha_i),
    .alpha_o(rb_alpha_o)
  );
endmodule

// File: rtl/frag_test_stage_chk.sv
module frag_test_stage_chk #(
  parameter int unsigned ZW = 24,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [ZW-1:0] frag_z_i,
  input logic [CW-1:0] z_cfg_i,
  input logic [1:0]    rb_mode_i,
  input logic [AW-1:0] rb_alpha_i,
  input logic          valid_o,
  input logic          pass_o,
  input logic          z_we_o,
  input logic [ZW-1:0] z_wdata_o,
  input logic [AW-1:0] rb_alpha_o
);
  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !pass_o && !z_we_o));
  // R5
  we_needs_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_we_o |-> (pass_o && valid_o));
  // R5
  we_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !z_cfg_i[4]) |=> !z_we_o);
  // R6
  wdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (z_wdata_o == $past(frag_z_i)));
  // R7
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(z_wdata_o));
  // R8
  rb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_mode_i == 2'd0) |-> (rb_alpha_o == '0));
  // R8
  rb_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_mode_i == 2'd1) |-> (rb_alpha_o == '1));
  // R8
  rb_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_mode_i[1] |-> (rb_alpha_o == rb_alpha_i));
endmodule

bind frag_test_stage frag_test_stage_chk #(.ZW(ZW), .AW(AW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .frag_z_i  (frag_z_i),
  .z_cfg_i   (z_cfg_i),
  .rb_mode_i (rb_mode_i),
  .rb_alpha_i(rb_alpha_i),
  .valid_o   (valid_o),
  .pass_o    (pass_o),
  .z_we_o    (z_we_o),
  .z_wdata_o (z_wdata_o),
  .rb_alpha_o(rb_alpha_o)
);

// File: tb/tb_frag_test_stage.sv
`timescale 1ns/1ps
module tb_frag_test_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] frag_z_i = '0, stored_z_i = '0;
  logic [7:0]  frag_alpha_i = '0;
  logic [15:0] z_cfg_i = '0, alpha_cfg_i = '0;
  logic [1:0]  rb_mode_i = '0;
  logic [7:0]  rb_alpha_i = '0;
  logic        valid_o, pass_o, z_we_o;
  logic [23:0] z_wdata_o;
  logic [7:0]  rb_alpha_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  frag_test_stage dut (.*);

  typedef struct packed {
    logic [15:0] zc;
    logic [15:0] ac;
    logic [23:0] fz;
    logic [23:0] sz;
    logic [7:0]  fa;
    logic        ep;
    logic        ew;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{16'h0011, 16'h0700, 24'd10, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 never
    '{16'h0013, 16'h0700, 24'd10, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 less
    '{16'h0013, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 less, equal in
    '{16'h0015, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 equal
    '{16'h0015, 16'h0700, 24'd21, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 equal miss
    '{16'h0017, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 le
    '{16'h0017, 16'h0700, 24'd21, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 le miss
    '{16'h0019, 16'h0700, 24'd21, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 gt
    '{16'h0019, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 gt miss
    '{16'h001B, 16'h0700, 24'd21, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 ne
    '{16'h001B, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 ne miss
    '{16'h001D, 16'h0700, 24'd20, 24'd20, 8'h00, 1'b1, 1'b1}, // R1 ge
    '{16'h001D, 16'h0700, 24'd19, 24'd20, 8'h00, 1'b0, 1'b0}, // R1 ge miss
    '{16'h001F, 16'h0700, 24'd0, 24'hFFFFFF, 8'h00, 1'b1, 1'b1}, // R1 always
    '{16'h0010, 16'h0700, 24'd50, 24'd10, 8'h00, 1'b1, 1'b1}, // R2 disabled
    '{16'h0003, 16'h0700, 24'd10, 24'd20, 8'h00, 1'b1, 1'b0}, // R5 no update
    '{16'h001F, 16'h0480, 24'd7, 24'd0, 8'h81, 1'b1, 1'b1}, // R3 gt thr
    '{16'h001F, 16'h0480, 24'd7, 24'd0, 8'h80, 1'b0, 1'b0}, // R3 gt miss
    '{16'h001F, 16'hFC80, 24'd7, 24'd0, 8'h81, 1'b1, 1'b1}, // R3 upper ignored
    '{16'h001F, 16'h0380, 24'd7, 24'd0, 8'h80, 1'b1, 1'b1}, // R3 le
    '{16'h001F, 16'h0000, 24'd7, 24'd0, 8'hFF, 1'b0, 1'b0}, // R4 alpha fails
    '{16'h0013, 16'h0700, 24'd30, 24'd20, 8'h00, 1'b0, 1'b0}, // R4 depth fails
    '{16'hFFE3, 16'h0700, 24'd10, 24'd20, 8'h00, 1'b1, 1'b0}  // R10 reserved set
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    z_cfg_i = v.zc; alpha_cfg_i = v.ac; frag_z_i = v.fz;
    stored_z_i = v.sz; frag_alpha_i = v.fa; valid_i = vld;
  endtask

  initial begin
    #5;
    chk("R9 valid", 32'(valid_o), 32'd0);
    chk("R9 pass", 32'(pass_o), 32'd0);
    chk("R9 we", 32'(z_we_o), 32'd0);
    chk("R9 wdata", 32'(z_wdata_o), 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i], 1'b1);
      @(negedge clk_i);
      chk("R7 valid_o", 32'(valid_o), 32'd1);
      chk($sformatf("R1/R4 pass vec%0d", i), 32'(pass_o), 32'(VECS[i].ep));
      chk($sformatf("R5 we vec%0d", i), 32'(z_we_o), 32'(VECS[i].ew));
      chk($sformatf("R6 wdata vec%0d", i), 32'(z_wdata_o), 32'(VECS[i].fz));
      valid_i = 1'b0;
    end

    // R7: idle cycle with a passing fragment on the bus
    @(negedge clk_i);
    drive(VECS[1], 1'b1);
    @(negedge clk_i);
    drive(VECS[13], 1'b0);
    @(negedge clk_i);
    chk("R7 idle valid", 32'(valid_o), 32'd0);
    chk("R7 idle pass", 32'(pass_o), 32'd0);
    chk("R7 idle we", 32'(z_we_o), 32'd0);
    chk("R7 wdata hold", 32'(z_wdata_o), 32'd10);

    // R8 readback modes
    rb_alpha_i = 8'h5A;
    rb_mode_i = 2'd0; #1 chk("R8 mode0", 32'(rb_alpha_o), 32'h00);
    rb_mode_i = 2'd1; #1 chk("R8 mode1", 32'(rb_alpha_o), 32'hFF);
    rb_mode_i = 2'd2; #1 chk("R8 mode2", 32'(rb_alpha_o), 32'h5A);
    rb_mode_i = 2'd3; #1 chk("R8 mode3", 32'(rb_alpha_o), 32'h5A);
    rb_alpha_i = 8'hC3; #1 chk("R8 mode3 follow", 32'(rb_alpha_o), 32'hC3);

    // R9: reset in mid-run
    @(negedge clk_i);
    drive(VECS[1], 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 midrun valid", 32'(valid_o), 32'd0);
    chk("R9 midrun pass", 32'(pass_o), 32'd0);
    chk("R9 midrun we", 32'(z_we_o), 32'd0);
    chk("R9 midrun wdata", 32'(z_wdata_o), 32'd0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule